// File: doc/BRIEF.md
# Tagged-Byte Serial Gain Register Interface

This block takes control bytes from a slow serial link and keeps a bank of gain settings: one master attenuation level and six channel gain levels. Each byte carries a type flag in its top bit. A byte with the flag set names a target register. A byte with the flag clear carries a value for the target named last. Because the flag travels in the byte, the block tells address bytes from data bytes by their content, not by where they fall in the stream.

The serial side has four inputs: a data line, a serial clock, an active-low write enable and a load strobe. Bits are taken on serial clock falling edges while the write enable is low. A decoded value only reaches its register when the load strobe rises. If the write enable and the load strobe are wired together, the link works as a plain three-wire interface.

All serial inputs are synchronised to the system clock. The serial clock is assumed to be far slower than the system clock. The master level is 7 bits wide and each channel level is 5 bits wide. The outputs feed the level converters downstream.

Top module: `ser_gain_regs`

## Requirements
- R1: After reset the master level is 127 (full attenuation) and every channel level is 0.
- R2: Bytes are 8 bits, most significant bit first. Each bit is sampled on a falling edge of `sclk_i`. The address byte 0x80 (top bit 1, code 0 in bits 6:0) followed by a data byte (top bit 0) loads bits 6:0 of the data byte into the master level. Exactly one register changes per commit.
- R3: The address codes 1 to 6 in bits 6:0 of an address byte select channels 1 to 6. The following data byte loads its bits 4:0 into that channel, and data bits 6:5 have no effect.
- R4: A data byte that follows an address byte with a code from 7 to 127 changes no output.
- R5: A data byte received while no address is pending is discarded and changes no output.
- R6: A value reaches its register only on a rising edge of `ld_i`. Until that edge all outputs keep their previous values.
- R7: If `wr_ni` goes high before the eighth bit of a byte, that partial byte is dropped and the bit count restarts at zero for the next byte.
- R8: Serial clock edges are ignored while `wr_ni` is high.
- R9: A commit clears the pending address. A later data byte that has no new address byte before it is discarded.
- R10: With `wr_ni` and `ld_i` driven together (three-wire use), an address frame followed by a data frame updates the addressed register. A rising edge of `ld_i` with no data staged leaves the pending address in place.
- R11: If several data bytes arrive before the load edge, the last one is committed. An address byte clears any staged data and replaces the pending address.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| sdata_i | input | 1 | Serial data line |
| sclk_i | input | 1 | Serial clock; bits are taken on its falling edge |
| wr_ni | input | 1 | Write enable (shift enable), active low |
| ld_i | input | 1 | Load strobe; a rising edge commits the staged value |
| master_o | output | 7 | Master attenuation level |
| chan_o | output | 30 | Channel gain levels; channel k occupies bits 5k-1 down to 5k-5 |

## Verification
A bit counter that is out of step puts bits in the wrong positions in every later byte. The tag bit is then misread, and the next committed value lands in the wrong register or carries a shifted value. Either error shows up on `master_o` or `chan_o` a few system cycles after the next rising edge of `ld_i`. A pending address or staged value that is wrongly kept or wrongly cleared is only visible at the next commit: a register changes when it should not, or keeps its value when it should change. For that reason every scenario is followed by a comparison of all seven outputs at once, so a write that reaches the wrong register is caught as well as one that is lost.

// File: rtl/gain_pkg.sv
package gain_pkg;
  localparam int unsigned BYTE_W = 8;
  localparam int unsigned CODE_W = BYTE_W - 1;
  localparam int unsigned CNT_W  = $clog2(BYTE_W);

  typedef logic [CODE_W-1:0] code_t;

  typedef struct packed {
    logic  valid;
    code_t addr;
    code_t data;
  } commit_t;
endpackage

// File: rtl/gsr_sync.sv
module gsr_sync #(
  parameter int unsigned W      = 4,
  parameter int unsigned STAGES = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] stg [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stg
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) stg[s] <= RST_VAL;
      else if (s == 0) stg[s] <= d_i;
      else stg[s] <= stg[(s == 0) ? 0 : s-1];
    end
  end

  assign q_o = stg[STAGES-1];
endmodule

// File: rtl/gsr_byte_rx.sv
module gsr_byte_rx
  import gain_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              sdata_i,
  input  logic              sclk_fall_i,
  input  logic              wr_n_i,
  output logic              byte_v_o,
  output logic [BYTE_W-1:0] byte_o,
  output logic [CNT_W-1:0]  bit_cnt_o
);
  logic [BYTE_W-1:0] sh_q;
  logic [CNT_W-1:0]  cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sh_q     <= '0;
      cnt_q    <= '0;
      byte_v_o <= 1'b0;
    end else begin
      byte_v_o <= 1'b0;
      if (wr_n_i) begin
        // deselect drops any partial byte
        sh_q  <= '0;
        cnt_q <= '0;
      end else if (sclk_fall_i) begin
        sh_q <= {sh_q[BYTE_W-2:0], sdata_i};
        if (cnt_q == CNT_W'(BYTE_W-1)) begin
          cnt_q    <= '0;
          byte_v_o <= 1'b1;
        end else begin
          cnt_q <= cnt_q + 1'b1;
        end
      end
    end
  end

  assign byte_o    = sh_q;
  assign bit_cnt_o = cnt_q;
endmodule

// File: rtl/gsr_tag_dec.sv
module gsr_tag_dec
  import gain_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              byte_v_i,
  input  logic [BYTE_W-1:0] byte_i,
  input  logic              ld_rise_i,
  output commit_t           commit_o,
  output logic              pend_v_o,
  output logic              staged_v_o
);
  code_t pend_addr_q, staged_q;
  logic  pend_v_q, staged_v_q;
  logic  fire, pend_now, is_addr;

  assign fire     = ld_rise_i & staged_v_q;
  assign pend_now = pend_v_q & ~fire;
  assign is_addr  = byte_i[BYTE_W-1];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pend_addr_q <= '0;
      staged_q    <= '0;
      pend_v_q    <= 1'b0;
      staged_v_q  <= 1'b0;
      commit_o    <= '0;
    end else begin
      commit_o.valid <= 1'b0;
      if (fire) begin
        commit_o.valid <= 1'b1;
        commit_o.addr  <= pend_addr_q;
        commit_o.data  <= staged_q;
        pend_v_q       <= 1'b0;
        staged_v_q     <= 1'b0;
      end
      if (byte_v_i) begin
        if (is_addr) begin
          pend_addr_q <= byte_i[CODE_W-1:0];
          pend_v_q    <= 1'b1;
          staged_v_q  <= 1'b0;
        end else if (pend_now) begin
          staged_q   <= byte_i[CODE_W-1:0];
          staged_v_q <= 1'b1;
        end
      end
    end
  end

  assign pend_v_o   = pend_v_q;
  assign staged_v_o = staged_v_q;
endmodule

// File: rtl/gsr_bank.sv
module gsr_bank
  import gain_pkg::*;
#(
  parameter int unsigned NUM_CH  = 6,
  parameter int unsigned MST_W   = 7,
  parameter int unsigned CH_W    = 5,
  parameter logic [MST_W-1:0] MST_RST = '1
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  commit_t                commit_i,
  output logic [MST_W-1:0]       master_o,
  output logic [NUM_CH*CH_W-1:0] chan_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) master_o <= MST_RST;
    else if (commit_i.valid && commit_i.addr == '0)
      master_o <= commit_i.data[MST_W-1:0];
  end

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) chan_o[c*CH_W +: CH_W] <= '0;
      else if (commit_i.valid && commit_i.addr == CODE_W'(c+1))
        chan_o[c*CH_W +: CH_W] <= commit_i.data[CH_W-1:0];
    end
  end
endmodule

// File: rtl/ser_gain_regs.sv
module ser_gain_regs
  import gain_pkg::*;
#(
  parameter int unsigned NUM_CH      = 6,
  parameter int unsigned MST_W       = 7,
  parameter int unsigned CH_W        = 5,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic                   sdata_i,
  input  logic                   sclk_i,
  input  logic                   wr_ni,
  input  logic                   ld_i,
  output logic [MST_W-1:0]       master_o,
  output logic [NUM_CH*CH_W-1:0] chan_o
);
  localparam logic [MST_W-1:0] MST_RST = '1;

  logic [3:0] raw, syn;
  logic sdata_s, sclk_s, wr_n_s, ld_s;
  logic sclk_d, ld_d;
  logic sclk_fall, ld_rise;
  logic byte_v;
  logic [BYTE_W-1:0] byte_w;
  logic [CNT_W-1:0]  bit_cnt;
  commit_t commit;
  logic pend_v, staged_v;

  assign raw = {ld_i, wr_ni, sclk_i, sdata_i};

  gsr_sync #(.W(4), .STAGES(SYNC_STAGES), .RST_VAL(4'b1110)) u_sync (
    .clk_i, .rst_ni, .d_i(raw), .q_o(syn)
  );
  assign {ld_s, wr_n_s, sclk_s, sdata_s} = syn;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sclk_d <= 1'b1;
      ld_d   <= 1'b1;
    end else begin
      sclk_d <= sclk_s;
      ld_d   <= ld_s;
    end
  end

  assign sclk_fall = sclk_d & ~sclk_s;
  assign ld_rise   = ~ld_d & ld_s;

  gsr_byte_rx u_rx (
    .clk_i, .rst_ni,
    .sdata_i(sdata_s), .sclk_fall_i(sclk_fall), .wr_n_i(wr_n_s),
    .byte_v_o(byte_v), .byte_o(byte_w), .bit_cnt_o(bit_cnt)
  );

  gsr_tag_dec u_dec (
    .clk_i, .rst_ni,
    .byte_v_i(byte_v), .byte_i(byte_w), .ld_rise_i(ld_rise),
    .commit_o(commit), .pend_v_o(pend_v), .staged_v_o(staged_v)
  );

  gsr_bank #(.NUM_CH(NUM_CH), .MST_W(MST_W), .CH_W(CH_W), .MST_RST(MST_RST)) u_bank (
    .clk_i, .rst_ni, .commit_i(commit), .master_o, .chan_o
  );
endmodule

// File: rtl/ser_gain_regs_chk.sv
module ser_gain_regs_chk
  import gain_pkg::*;
#(
  parameter int unsigned NUM_CH = 6,
  parameter int unsigned MST_W  = 7,
  parameter int unsigned CH_W   = 5
) (
  input logic                   clk_i,
  input logic                   rst_ni,
  input logic [MST_W-1:0]       master_o,
  input logic [NUM_CH*CH_W-1:0] chan_o,
  input commit_t                commit,
  input logic                   pend_v,
  input logic                   staged_v,
  input logic                   wr_n_s,
  input logic                   byte_v,
  input logic [CNT_W-1:0]       bit_cnt
);
  AST_HOLD_NO_LOAD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !commit.valid |=> $stable(master_o) && $stable(chan_o)); // R6

  AST_ONE_TARGET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(master_o) |-> $stable(chan_o)); // R2

  AST_BAD_CODE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    commit.valid && commit.addr > CODE_W'(NUM_CH) |=> $stable(master_o) && $stable(chan_o)); // R4

  AST_STAGE_NEEDS_ADDR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    staged_v |-> pend_v); // R5

  AST_CNT_CLEAR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_n_s |=> bit_cnt == '0); // R7

  AST_IDLE_NO_BYTE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_n_s |=> !byte_v); // R8
endmodule

bind ser_gain_regs ser_gain_regs_chk #(.NUM_CH(NUM_CH), .MST_W(MST_W), .CH_W(CH_W)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .master_o(master_o), .chan_o(chan_o),
  .commit(commit), .pend_v(pend_v), .staged_v(staged_v),
  .wr_n_s(wr_n_s), .byte_v(byte_v), .bit_cnt(bit_cnt)
);

// File: tb/sim_ser_gain_regs.sv
module sim_ser_gain_regs;
  localparam int NCH  = 6;
  localparam int CW   = 5;
  localparam int MW   = 7;
  localparam int HALF = 8;

  logic clk = 1'b0, rst_n = 1'b0;
  logic sdata = 1'b0, sclk = 1'b1, wr_n = 1'b1, ld = 1'b1;
  logic [MW-1:0]     master;
  logic [NCH*CW-1:0] chan;

  int n_cmp = 0, n_bad = 0;
  bit done = 1'b0;

  logic [MW-1:0] exp_m;
  logic [CW-1:0] exp_c [NCH];

  logic [MW+NCH*CW-1:0] q_exp [$];
  string q_tag [$];
  event chk_ev;

  always #2 clk = ~clk;

  ser_gain_regs u0 (
    .clk_i(clk), .rst_ni(rst_n), .sdata_i(sdata), .sclk_i(sclk),
    .wr_ni(wr_n), .ld_i(ld), .master_o(master), .chan_o(chan)
  );

  task automatic wait_clk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic put_bit(input logic b);
    sdata = b;
    wait_clk(HALF);
    sclk = 1'b0;
    wait_clk(HALF);
    sclk = 1'b1;
  endtask

  task automatic send_bits(input logic [7:0] b, input int n);
    for (int i = 7; i > 7 - n; i--) put_bit(b[i]);
  endtask

  task automatic frame3(input logic [7:0] b);
    wr_n = 1'b0; ld = 1'b0;
    wait_clk(HALF);
    send_bits(b, 8);
    wait_clk(HALF);
    wr_n = 1'b1; ld = 1'b1;
    wait_clk(2*HALF);
  endtask

  task automatic ld_pulse();
    ld = 1'b0;
    wait_clk(HALF);
    ld = 1'b1;
    wait_clk(HALF);
  endtask

  function automatic void model(input logic [6:0] a, input logic [6:0] d);
    if (a == 0) exp_m = d[MW-1:0];
    else if (a <= NCH) exp_c[a-1] = d[CW-1:0];
  endfunction

  task automatic expect_now(input string tag);
    logic [NCH*CW-1:0] cv;
    wait_clk(12);
    for (int k = 0; k < NCH; k++) cv[k*CW +: CW] = exp_c[k];
    q_exp.push_back({exp_m, cv});
    q_tag.push_back(tag);
    -> chk_ev;
    wait_clk(1);
  endtask

  // monitor / scoreboard
  initial begin
    forever begin
      @(chk_ev);
      while (q_exp.size() > 0) begin
        logic [MW+NCH*CW-1:0] e;
        string t;
        e = q_exp.pop_front();
        t = q_tag.pop_front();
        n_cmp++;
        if (master !== e[NCH*CW +: MW]) begin
          n_bad++;
          $display("FAIL %s master: actual %0d expected %0d", t, master, e[NCH*CW +: MW]);
        end
        for (int k = 0; k < NCH; k++) begin
          n_cmp++;
          if (chan[k*CW +: CW] !== e[k*CW +: CW]) begin
            n_bad++;
            $display("FAIL %s chan%0d: actual %0d expected %0d", t, k+1,
                     chan[k*CW +: CW], e[k*CW +: CW]);
          end
        end
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    exp_m = 7'd127;
    for (int k = 0; k < NCH; k++) exp_c[k] = '0;
    wait_clk(4);
    rst_n = 1'b1;
    wait_clk(4);
    expect_now("R1 reset");

    // R2 R10: master through three-wire frames
    frame3(8'h80); expect_now("R10 addr only, no commit");
    frame3(8'h55); model(0, 7'h55); expect_now("R2 R10 master");

    // R3: each channel, upper data bits set
    for (int k = 1; k <= NCH; k++) begin
      frame3(8'h80 | 8'(k));
      frame3(8'h60 | 8'(k*5));
      model(7'(k), 7'h60 | 7'(k*5));
    end
    expect_now("R3 channels");

    // R4: codes outside the map
    frame3(8'h87); frame3(8'h11);
    frame3(8'hFF); frame3(8'h1F);
    expect_now("R4 bad codes");

    // R5 R9: data with no pending address after a commit
    frame3(8'h22);
    expect_now("R5 R9 orphan data");

    // R6: four-wire, outputs hold until ld rises
    wr_n = 1'b0; wait_clk(HALF);
    send_bits(8'h80, 8); send_bits(8'h0A, 8);
    wait_clk(HALF); wr_n = 1'b1;
    expect_now("R6 before load");
    ld_pulse(); model(0, 7'h0A);
    expect_now("R6 after load");

    // R7: partial byte dropped, counter restarts
    frame3(8'h82);
    wr_n = 1'b0; ld = 1'b0; wait_clk(HALF);
    send_bits(8'h1F, 4);
    wait_clk(HALF); wr_n = 1'b1; ld = 1'b1; wait_clk(2*HALF);
    expect_now("R7 partial byte");
    frame3(8'h09); model(2, 7'h09);
    expect_now("R7 byte after partial");

    // R8: clocks while deselected are ignored
    send_bits(8'h83, 8);
    frame3(8'h04);
    expect_now("R8 idle clocks");

    // R11: last data wins; address clears staged data
    wr_n = 1'b0; wait_clk(HALF);
    send_bits(8'h84, 8); send_bits(8'h01, 8); send_bits(8'h07, 8);
    wait_clk(HALF); wr_n = 1'b1;
    ld_pulse(); model(4, 7'h07);
    expect_now("R11 last data wins");
    wr_n = 1'b0; wait_clk(HALF);
    send_bits(8'h85, 8); send_bits(8'h03, 8); send_bits(8'h86, 8);
    wait_clk(HALF); wr_n = 1'b1;
    ld_pulse();
    expect_now("R11 addr clears staged");
    frame3(8'h0C); model(6, 7'h0C);
    expect_now("R11 new pending addr");

    // R2 range ends
    frame3(8'h80); frame3(8'h7F); model(0, 7'h7F);
    expect_now("R2 master max");
    frame3(8'h80); frame3(8'h00); model(0, 7'h00);
    expect_now("R2 master zero");

    wait_clk(4);
    done = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule